// File: doc/BRIEF.md
# Paged SPI Register Access Frontend

This block is the slave side of a 16-bit word protocol that gives a host processor access to the register banks of a sensor and codec controller over SPI. The words alternate between command and data. A command word carries a read flag, a page number and a register offset. The word that follows it is either the data to write or the trigger that fetches a register. Once a read has started, zero words keep fetching and step the offset forward, so a single command can walk through a block of registers.

The frontend drives a page, an offset and single-cycle read and write strobes toward the register banks. It accepts read data, one cycle after the read strobe, together with a hit flag that says whether the register exists. It returns the result on MISO during the next word. It also spots the key value written to the device reset register and raises a one-cycle device reset pulse. It flags three protocol errors: a data word that arrives after a read command, an access to a page that does not exist, and a word cut short by chip select.

The SPI pins are synchronised into the system clock. SCK must therefore run well below the system clock. MOSI is sampled on the rising SCK edge and MISO changes after the falling edge, most significant bit first.

Top module: `paged_spi_frontend`

## Requirements
- R1: After reset, MISO is low, no strobe or error pulse is active, and the engine expects a command word.
- R2: In a command word, bit 15 is the read flag, bits 14:11 are the page and bits 10:5 are the offset. A command with bit 15 clear, followed by a data word, gives exactly one `reg_wr` pulse carrying that page, offset and data word. A zero data word is also written.
- R3: A command with bit 15 set, followed by a zero word, gives one `reg_rd` pulse at that page and offset. The read data, sent MSB first, appears on MISO during the next 16-bit word.
- R4: After each read the offset rises by one. A zero word received while a command is expected reads again at the current page and offset, so repeated zero words return consecutive registers.
- R5: A nonzero word received after a read command still performs the read. It also pulses `err_overrun` and produces no write. The word is discarded, and the engine then expects a command.
- R6: Only pages 0, 1 and 2 exist. An access to any higher page gives no strobe and pulses `err_page`. A read of such a page returns 0xFFFF.
- R7: Writing 0xBB00 to page 1, offset 4 gives a one-cycle `dev_reset` pulse and no `reg_wr`. Writing any other value there has no effect at the ports.
- R8: A read that the bank answers with `reg_rhit` low returns 0xFFFF.
- R9: If chip select rises after 1 to 15 bits of a word, the partial word is discarded and `err_frame` pulses. The engine returns to expecting a command, and the next word returns zero on MISO.
- R10: Every word that does not start a read makes the following word return 0x0000 on MISO.
- R11: In any cycle at most one of `reg_rd`, `reg_wr` and `dev_reset` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, MSB first |
| reg_page | output | 4 | Page of the current access |
| reg_offset | output | 6 | Register offset of the current access |
| reg_rd | output | 1 | Read strobe toward the banks |
| reg_wr | output | 1 | Write strobe toward the banks |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data, valid one cycle after `reg_rd` |
| reg_rhit | input | 1 | Register exists; valid with `reg_rdata` |
| dev_reset | output | 1 | One-cycle device reset pulse |
| err_overrun | output | 1 | Data word received after a read command |
| err_page | output | 1 | Access to a page that does not exist |
| err_frame | output | 1 | Word cut short by chip select |

## Verification
The assertions assume that SCK and MOSI stay steady for several system clocks around every edge. With that margin, a completed word is seen only long after the read pipeline of the previous word has drained, and a word completion can never land in the same cycle as a partial-word abort. The stimulus runs each SCK half-period over ten system clocks, changes MOSI only while SCK is low, and toggles chip select only with SCK low. The register bank answers every `reg_rd` in the very next cycle.

// File: rtl/psf_pkg.sv
package psf_pkg;
  localparam int WORD_W  = 16;
  localparam int PAGE_W  = 4;
  localparam int OFF_W   = 6;
  localparam int CNT_W   = $clog2(WORD_W);
  // field positions in the command word
  localparam int RD_BIT  = 15;
  localparam int PG_LSB  = 11;
  localparam int OFF_LSB = 5;

  typedef enum logic {PH_CMD, PH_DATA} phase_e;

  typedef struct packed {
    logic              rd;
    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  off;
  } cmd_t;

  function automatic cmd_t cmd_decode(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.rd   = w[RD_BIT];
    c.page = w[PG_LSB +: PAGE_W];
    c.off  = w[OFF_LSB +: OFF_W];
    return c;
  endfunction

  function automatic logic page_ok(input logic [PAGE_W-1:0] p, input int num_pages);
    return int'(p) < num_pages;
  endfunction

  function automatic logic [WORD_W-1:0] read_result(input logic fwd, input logic hit,
                                                    input logic [WORD_W-1:0] data);
    return (fwd && hit) ? data : {WORD_W{1'b1}};
  endfunction
endpackage

// File: rtl/psf_spi_rx.sv
module psf_spi_rx
  import psf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              word_vld,
  output logic [WORD_W-1:0] word,
  output logic              frame_abort,
  output logic              shift_en
);
  logic [SYNC_STAGES:0]   sck_p;
  logic [SYNC_STAGES-1:0] cs_p;
  logic [SYNC_STAGES-1:0] mosi_p;
  logic [WORD_W-1:0]      sh;
  logic [CNT_W-1:0]       cnt;
  logic sck_s, sck_d, cs_s, mosi_s, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[SYNC_STAGES-1:0], sck};
      cs_p   <= {cs_p[SYNC_STAGES-2:0], cs_n};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi};
    end
  end

  assign sck_s  = sck_p[SYNC_STAGES-1];
  assign sck_d  = sck_p[SYNC_STAGES];
  assign cs_s   = cs_p[SYNC_STAGES-1];
  assign mosi_s = mosi_p[SYNC_STAGES-1];
  assign rise   = sck_s & ~sck_d;
  assign fall   = ~sck_s & sck_d;
  // no shift on the falling edge that closes a word: the next word's data is loaded there
  assign shift_en = fall & ~cs_s & (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh          <= '0;
      cnt         <= '0;
      word        <= '0;
      word_vld    <= 1'b0;
      frame_abort <= 1'b0;
    end else begin
      word_vld    <= 1'b0;
      frame_abort <= 1'b0;
      if (cs_s) begin
        if (cnt != '0) frame_abort <= 1'b1;
        cnt <= '0;
      end else if (rise) begin
        sh  <= {sh[WORD_W-2:0], mosi_s};
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(WORD_W - 1)) begin
          word_vld <= 1'b1;
          word     <= {sh[WORD_W-2:0], mosi_s};
        end
      end
    end
  end
endmodule

// File: rtl/psf_spi_tx.sv
module psf_spi_tx
  import psf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              shift_en,
  output logic              miso
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh <= '0;
    else if (load)     sh <= load_data;
    else if (shift_en) sh <= {sh[WORD_W-2:0], 1'b0};
  end

  assign miso = sh[WORD_W-1];
endmodule

// File: rtl/psf_cmd_engine.sv
module psf_cmd_engine
  import psf_pkg::*;
#(
  parameter int              NUM_PAGES = 3,
  parameter int              CTRL_PAGE = 1,
  parameter int              RST_OFF   = 4,
  parameter logic [WORD_W-1:0] RST_KEY = 16'hBB00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  input  logic              frame_abort,
  input  logic [WORD_W-1:0] reg_rdata,
  input  logic              reg_rhit,
  output logic [PAGE_W-1:0] reg_page,
  output logic [OFF_W-1:0]  reg_offset,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              dev_reset,
  output logic              err_overrun,
  output logic              err_page,
  output logic              tx_load,
  output logic [WORD_W-1:0] tx_data
);
  phase_e phase;
  logic   pend_rd;
  logic   rd_s1, rd_s2, fwd_s1, fwd_s2, zero_ld;
  cmd_t   cmd;
  logic   in_cmd, want_rd, want_wr, page_bad, is_rst, rd_fwd, wr_fwd;

  assign cmd      = cmd_decode(word);
  assign in_cmd   = (phase == PH_CMD);
  assign want_rd  = word_vld && ((in_cmd && word == '0) || (!in_cmd && pend_rd));
  assign want_wr  = word_vld && !in_cmd && !pend_rd;
  assign page_bad = !page_ok(reg_page, NUM_PAGES);
  assign is_rst   = (int'(reg_page) == CTRL_PAGE) && (int'(reg_offset) == RST_OFF);
  assign rd_fwd   = want_rd && !page_bad && !is_rst;
  assign wr_fwd   = want_wr && !page_bad && !is_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_CMD;
      pend_rd     <= 1'b0;
      reg_page    <= '0;
      reg_offset  <= '0;
      reg_rd      <= 1'b0;
      reg_wr      <= 1'b0;
      reg_wdata   <= '0;
      dev_reset   <= 1'b0;
      err_overrun <= 1'b0;
      err_page    <= 1'b0;
      rd_s1       <= 1'b0;
      rd_s2       <= 1'b0;
      fwd_s1      <= 1'b0;
      fwd_s2      <= 1'b0;
      zero_ld     <= 1'b0;
    end else begin
      reg_rd      <= rd_fwd;
      reg_wr      <= wr_fwd;
      dev_reset   <= want_wr && is_rst && (word == RST_KEY);
      err_page    <= (want_rd || want_wr) && page_bad;
      err_overrun <= word_vld && !in_cmd && pend_rd && (word != '0);
      rd_s1       <= want_rd;
      fwd_s1      <= rd_fwd;
      rd_s2       <= rd_s1;
      fwd_s2      <= fwd_s1;
      zero_ld     <= (word_vld && !want_rd) || frame_abort;
      if (wr_fwd) reg_wdata <= word;
      // the bank samples the offset with reg_rd; step it on that same edge
      if (rd_s1) reg_offset <= reg_offset + 1'b1;
      if (frame_abort) begin
        phase <= PH_CMD;
      end else if (word_vld) begin
        if (in_cmd && word != '0) begin
          pend_rd    <= cmd.rd;
          reg_page   <= cmd.page;
          reg_offset <= cmd.off;
          phase      <= PH_DATA;
        end else begin
          phase <= PH_CMD;
        end
      end
    end
  end

  assign tx_load = rd_s2 || zero_ld;
  assign tx_data = rd_s2 ? read_result(fwd_s2, reg_rhit, reg_rdata) : '0;
endmodule

// File: rtl/paged_spi_frontend.sv
module paged_spi_frontend
  import psf_pkg::*;
#(
  parameter int                NUM_PAGES   = 3,
  parameter int                CTRL_PAGE   = 1,
  parameter int                RST_OFF     = 4,
  parameter logic [WORD_W-1:0] RST_KEY     = 16'hBB00,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [PAGE_W-1:0] reg_page,
  output logic [OFF_W-1:0]  reg_offset,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [WORD_W-1:0] reg_wdata,
  input  logic [WORD_W-1:0] reg_rdata,
  input  logic              reg_rhit,
  output logic              dev_reset,
  output logic              err_overrun,
  output logic              err_page,
  output logic              err_frame
);
  // internal events, named for the checker
  logic              word_vld;
  logic [WORD_W-1:0] word;
  logic              frame_abort;
  logic              shift_en;
  logic              tx_load;
  logic [WORD_W-1:0] tx_data;

  psf_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .word_vld(word_vld), .word(word), .frame_abort(frame_abort), .shift_en(shift_en)
  );

  psf_cmd_engine #(
    .NUM_PAGES(NUM_PAGES), .CTRL_PAGE(CTRL_PAGE), .RST_OFF(RST_OFF), .RST_KEY(RST_KEY)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word), .frame_abort(frame_abort),
    .reg_rdata(reg_rdata), .reg_rhit(reg_rhit), .reg_page(reg_page), .reg_offset(reg_offset),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .dev_reset(dev_reset),
    .err_overrun(err_overrun), .err_page(err_page), .tx_load(tx_load), .tx_data(tx_data)
  );

  psf_spi_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_data(tx_data),
    .shift_en(shift_en), .miso(spi_miso)
  );

  assign err_frame = frame_abort;
endmodule

// File: rtl/psf_checker.sv
module psf_checker
  import psf_pkg::*;
#(
  parameter int NUM_PAGES = 3,
  parameter int CTRL_PAGE = 1,
  parameter int RST_OFF   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic              dev_reset,
  input logic [PAGE_W-1:0] reg_page,
  input logic [OFF_W-1:0]  reg_offset,
  input logic              err_overrun,
  input logic              word_vld,
  input logic              frame_abort
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_rd, reg_wr, dev_reset})); // R11
  AST_RD_STEPS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> (reg_offset == OFF_W'($past(reg_offset) + 1'b1))); // R4
  AST_OVERRUN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |-> !reg_wr); // R5
  AST_WR_PAGE_EXISTS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (int'(reg_page) < NUM_PAGES)); // R6
  AST_RESET_REG_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !((int'(reg_page) == CTRL_PAGE) && (int'(reg_offset) == RST_OFF))); // R7
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |=> !dev_reset); // R7
  AST_ABORT_NOT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_vld && frame_abort)); // R9
endmodule

bind paged_spi_frontend psf_checker #(
  .NUM_PAGES(NUM_PAGES), .CTRL_PAGE(CTRL_PAGE), .RST_OFF(RST_OFF)
) u_psf_checker (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .dev_reset(dev_reset),
  .reg_page(reg_page), .reg_offset(reg_offset), .err_overrun(err_overrun),
  .word_vld(word_vld), .frame_abort(frame_abort)
);

// File: tb/tb_paged_spi_frontend.sv
`timescale 1ns/1ps
module tb_paged_spi_frontend;
  localparam int HALF = 10;
  localparam int IMPL_LIMIT = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic [3:0] reg_page;
  logic [5:0] reg_offset;
  logic reg_rd, reg_wr, reg_rhit, dev_reset, err_overrun, err_page, err_frame;
  logic [15:0] reg_wdata, reg_rdata;

  int tests = 0, fails = 0, cycles = 0;
  int wr_n = 0, rd_n = 0, dr_n = 0, ovr_n = 0, pg_n = 0, fr_n = 0, excl_bad = 0;
  int last_wp, last_wo, last_wd, last_rp, last_ro;

  always #4 clk = ~clk;

  paged_spi_frontend dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .reg_page(reg_page), .reg_offset(reg_offset), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rhit(reg_rhit),
    .dev_reset(dev_reset), .err_overrun(err_overrun), .err_page(err_page), .err_frame(err_frame)
  );

  function automatic logic [15:0] bank_val(input int p, input int o);
    return 16'((p + 7) * 4099 + o * 131);
  endfunction

  function automatic logic [15:0] mk(input int rd, input int p, input int o);
    return 16'(rd * 32768 + p * 2048 + o * 32);
  endfunction

  // register bank model: one-cycle registered read
  always @(posedge clk) begin
    if (reg_rd) begin
      reg_rdata <= bank_val(int'(reg_page), int'(reg_offset));
      reg_rhit  <= int'(reg_offset) < IMPL_LIMIT;
    end
  end

  // per-clock monitor
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (int'(reg_rd) + int'(reg_wr) + int'(dev_reset) > 1) excl_bad++;
      if (reg_wr) begin wr_n++; last_wp = reg_page; last_wo = reg_offset; last_wd = reg_wdata; end
      if (reg_rd) begin rd_n++; last_rp = reg_page; last_ro = reg_offset; end
      if (dev_reset) dr_n++;
      if (err_overrun) ovr_n++;
      if (err_page) pg_n++;
      if (err_frame) fr_n++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_low();
    spi_cs_n = 1'b0;
    wclk(HALF);
  endtask

  task automatic xfer(input logic [15:0] tx, output logic [15:0] rx);
    for (int i = 15; i >= 0; i--) begin
      spi_mosi = tx[i];
      wclk(HALF);
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      wclk(HALF);
      spi_sck = 1'b0;
    end
    wclk(HALF);
  endtask

  task automatic partial(input int nbits);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = i[0];
      wclk(HALF);
      spi_sck = 1'b1;
      wclk(HALF);
      spi_sck = 1'b0;
    end
    wclk(HALF);
    spi_cs_n = 1'b1;
    wclk(3 * HALF);
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] rx;
    int s0, s1;
    wclk(5);
    rst_n = 1'b1;
    wclk(3);
    // R1 reset state
    check("R1 miso", int'(spi_miso), 0);
    check("R1 strobes", int'(reg_rd) + int'(reg_wr) + int'(dev_reset), 0);
    check("R1 errors", int'(err_overrun) + int'(err_page) + int'(err_frame), 0);

    cs_low();
    // R2 write command then data
    xfer(mk(0, 2, 5), rx);
    xfer(16'h1234, rx);
    check("R2 write count", wr_n, 1);
    check("R2 page", last_wp, 2);
    check("R2 offset", last_wo, 5);
    check("R2 data", last_wd, 16'h1234);
    // R2 zero data word is still written
    xfer(mk(0, 0, 9), rx);
    xfer(16'h0000, rx);
    check("R2 zero write count", wr_n, 2);
    check("R2 zero write offset", last_wo, 9);
    // R10 after a write word, next word returns zero
    xfer(mk(1, 0, 3), rx);
    check("R10 miso after write", rx, 0);
    xfer(16'h0000, rx);
    check("R10 miso after command", rx, 0);
    check("R3 read page", last_rp, 0);
    check("R3 read offset", last_ro, 3);
    xfer(16'h0000, rx);
    check("R3 read data", rx, bank_val(0, 3));
    check("R4 next offset", last_ro, 4);
    xfer(16'h0000, rx);
    check("R4 sequential data", rx, bank_val(0, 4));

    // R5 overrun
    xfer(mk(1, 1, 2), rx);
    check("R4 third sequential data", rx, bank_val(0, 5));
    s0 = ovr_n; s1 = wr_n;
    xfer(16'h00F0, rx);
    check("R5 overrun pulse", ovr_n, s0 + 1);
    check("R5 no write", wr_n, s1);
    check("R5 read still done", last_ro, 2);
    xfer(16'h0000, rx);
    check("R5 read data", rx, bank_val(1, 2));

    // R6 bad page
    xfer(mk(0, 5, 1), rx);
    check("R4 after overrun data", rx, bank_val(1, 3));
    s0 = pg_n; s1 = wr_n;
    xfer(16'hAAAA, rx);
    check("R6 write page error", pg_n, s0 + 1);
    check("R6 no write", wr_n, s1);
    xfer(mk(1, 7, 0), rx);
    s1 = rd_n;
    xfer(16'h0000, rx);
    check("R6 read page error", pg_n, s0 + 2);
    check("R6 no read strobe", rd_n, s1);
    xfer(mk(0, 2, 9), rx);
    check("R6 read returns ones", rx, 16'hFFFF);
    xfer(16'h0BAD, rx);

    // R7 reset register
    s0 = dr_n; s1 = wr_n;
    xfer(mk(0, 1, 4), rx);
    xfer(16'h1234, rx);
    check("R7 wrong key no reset", dr_n, s0);
    check("R7 wrong key no write", wr_n, s1);
    xfer(mk(0, 1, 4), rx);
    xfer(16'hBB00, rx);
    check("R7 key gives reset", dr_n, s0 + 1);
    check("R7 key no write", wr_n, s1);

    // R8 unimplemented register
    s0 = rd_n;
    xfer(mk(1, 2, 30), rx);
    xfer(16'h0000, rx);
    check("R8 read issued", rd_n, s0 + 1);
    xfer(mk(0, 0, 1), rx);
    check("R8 miss returns ones", rx, 16'hFFFF);
    xfer(16'h0001, rx);

    // R9 partial word abort
    s0 = fr_n;
    partial(7);
    check("R9 frame error", fr_n, s0 + 1);
    cs_low();
    xfer(mk(0, 2, 1), rx);
    check("R9 zero after abort", rx, 0);
    xfer(16'h5555, rx);
    check("R9 write after abort", last_wd, 16'h5555);
    xfer(mk(0, 2, 3), rx);
    partial(5);
    cs_low();
    s1 = wr_n;
    xfer(mk(0, 0, 1), rx);
    check("R9 phase back to command", wr_n, s1);
    xfer(16'h7777, rx);
    check("R9 write count", wr_n, s1 + 1);
    check("R9 write data", last_wd, 16'h7777);
    spi_cs_n = 1'b1;
    wclk(20);

    check("R11 strobe exclusivity over run", excl_bad, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule